// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core and decides when the core enters a handler. It watches three request sources: a software break with its own trap vector, a memory-management fault with its own fault vector, and an external interrupt whose vector comes from an interrupt controller. When it accepts a request, it snapshots the current program counter, status word and exception base. It then fetches the handler address from a vector table through a single memory read port.

When the table word returns, the block commits three things in the same cycle. The program counter becomes the fetched word. The return-address register gets the address that suits the kind of entry. The status word is rewritten by a stacked shift that keeps the two top bits. The core watches a one-cycle commit strobe and the busy flag. Interrupts with a vector in the range reserved for internal exceptions are dropped. Interrupts that arrive while the enable flag is clear are left pending on their input.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `pc_o`, `erp_o` and `ccs_o` are zero, and `busy_o`, `commit_o` and `rd_valid_o` are low.
- R2: The table read address on `rd_addr_o` is `ebp_i + vector*4`, taken from the values present at acceptance. `rd_valid_o` and `rd_addr_o` stay unchanged until a cycle with `rd_ready_i` high.
- R3: A break request uses `brk_vec_i` as the vector and writes `pc_i + 2` into `erp_o`.
- R4: A fault request uses `mmu_vec_i` as the vector and leaves `erp_o` at its previous value.
- R5: An interrupt request whose `irq_vec_i` is below 0x30 starts no entry. The block stays idle, issues no read and leaves every register output unchanged. A vector of exactly 0x30 is accepted.
- R6: An interrupt request is not taken while bit `IFLAG_BIT` of `ccs_i` is 0. If it is still asserted when that bit becomes 1, it is then taken.
- R7: An accepted interrupt uses `irq_vec_i` as the vector and writes `pc_i` into `erp_o`.
- R8: On every entry, `ccs_o` becomes `{old[31:30], old[19:0], 10'b0}`, where `old` is `ccs_i` at acceptance.
- R9: When requests coincide, a break wins over a fault, and a fault wins over an interrupt.
- R10: In the clock cycle after a handshake on `rd_rvalid_i`, `pc_o` holds the returned word, and `erp_o` and `ccs_o` hold their new values. `commit_o` is high for exactly that one cycle. At no other time do the register outputs change.
- R11: `busy_o` goes high in the cycle after acceptance and stays high until the commit. Requests are not sampled while busy, and a request still present after the commit is accepted on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current program counter |
| ccs_i | input | 32 | Current status word |
| ebp_i | input | 32 | Exception table base |
| brk_req_i | input | 1 | Break request |
| brk_vec_i | input | VEC_W | Break trap vector |
| mmu_req_i | input | 1 | Memory-management fault request |
| mmu_vec_i | input | VEC_W | Fault vector |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_i | input | VEC_W | Interrupt vector from the controller |
| rd_valid_o | output | 1 | Table read request valid |
| rd_addr_o | output | 32 | Table read byte address |
| rd_ready_i | input | 1 | Table read request accepted |
| rd_rvalid_i | input | 1 | Table read data valid |
| rd_data_i | input | 32 | Table read data (handler address) |
| busy_o | output | 1 | Entry in progress |
| commit_o | output | 1 | One-cycle strobe: new register values present |
| pc_o | output | 32 | New program counter |
| erp_o | output | 32 | Saved return address |
| ccs_o | output | 32 | New status word |

## Verification
The bench builds the block with `VEC_W` = 8 and `IFLAG_BIT` = 3. With an 8-bit vector, both 0x2F and 0x30 can be driven, so the reserved-range boundary is tested from both sides. With the enable flag at bit 3, that flag falls inside the field that the status rewrite clears. This shows that the flag position follows the parameter and that the rewrite still clears the flag's bit. The memory model varies its ready and response delays from zero to three cycles, which exercises a request held across stalls and a busy window of several lengths.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W     = 8,
  parameter int IFLAG_BIT = 8,
  parameter int IRQ_FLOOR = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      pc_i,
  input  logic [31:0]      ccs_i,
  input  logic [31:0]      ebp_i,
  input  logic             brk_req_i,
  input  logic [VEC_W-1:0] brk_vec_i,
  input  logic             mmu_req_i,
  input  logic [VEC_W-1:0] mmu_vec_i,
  input  logic             irq_req_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  output logic             rd_valid_o,
  output logic [31:0]      rd_addr_o,
  input  logic             rd_ready_i,
  input  logic             rd_rvalid_i,
  input  logic [31:0]      rd_data_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic [31:0]      pc_o,
  output logic [31:0]      erp_o,
  output logic [31:0]      ccs_o
);

  localparam int PAD_W = 32 - VEC_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_t;
  st_t st;

  logic [31:0]      addr_q, ret_q, ccs_nx_q, pc_q, erp_q, ccs_q;
  logic             ret_we_q, commit_q;
  logic [VEC_W-1:0] vec;

  wire irq_ok = irq_req_i && (irq_vec_i >= VEC_W'(IRQ_FLOOR)) && ccs_i[IFLAG_BIT];
  wire take   = (st == S_IDLE) && (brk_req_i || mmu_req_i || irq_ok);

  always_comb begin
    if (brk_req_i)      vec = brk_vec_i;
    else if (mmu_req_i) vec = mmu_vec_i;
    else                vec = irq_vec_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      ret_q    <= '0;
      ret_we_q <= 1'b0;
      ccs_nx_q <= '0;
      pc_q     <= '0;
      erp_q    <= '0;
      ccs_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          st       <= S_REQ;
          addr_q   <= ebp_i + {{PAD_W{1'b0}}, vec, 2'b00};
          ret_q    <= brk_req_i ? pc_i + 32'd2 : pc_i;
          ret_we_q <= brk_req_i || !mmu_req_i;
          ccs_nx_q <= {ccs_i[31:30], 30'(ccs_i[29:0] << 10)};
        end
        S_REQ: if (rd_ready_i) st <= S_RSP;
        S_RSP: if (rd_rvalid_i) begin
          st       <= S_IDLE;
          pc_q     <= rd_data_i;
          ccs_q    <= ccs_nx_q;
          if (ret_we_q) erp_q <= ret_q;
          commit_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_valid_o = (st == S_REQ);
  assign rd_addr_o  = addr_q;
  assign busy_o     = (st != S_IDLE);
  assign commit_o   = commit_q;
  assign pc_o       = pc_q;
  assign erp_o      = erp_q;
  assign ccs_o      = ccs_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R2
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_valid_o); // R11
  AST_COMMIT_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !rd_valid_o && rd_rvalid_i |=> commit_o && !busy_o); // R10
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R10
  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |-> $stable(pc_o) && $stable(erp_o) && $stable(ccs_o)); // R10
  AST_CCS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ccs_o[9:0] == 10'd0); // R8

endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam int VEC_W = 8;
  localparam int IFB   = 3;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc_i = 0, ccs_i = 0, ebp_i = 0;
  logic brk_req_i = 0, mmu_req_i = 0, irq_req_i = 0;
  logic [VEC_W-1:0] brk_vec_i = 0, mmu_vec_i = 0, irq_vec_i = 0;
  logic rd_ready_i = 0, rd_rvalid_i = 0;
  logic [31:0] rd_data_i = 0;
  logic rd_valid_o, busy_o, commit_o;
  logic [31:0] rd_addr_o, pc_o, erp_o, ccs_o;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  exc_entry_seq #(.VEC_W(VEC_W), .IFLAG_BIT(IFB)) dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ccs_i(ccs_i), .ebp_i(ebp_i),
    .brk_req_i(brk_req_i), .brk_vec_i(brk_vec_i), .mmu_req_i(mmu_req_i),
    .mmu_vec_i(mmu_vec_i), .irq_req_i(irq_req_i), .irq_vec_i(irq_vec_i),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i),
    .rd_rvalid_i(rd_rvalid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .commit_o(commit_o), .pc_o(pc_o), .erp_o(erp_o), .ccs_o(ccs_o));

  function automatic logic [31:0] tbl(input logic [31:0] a);
    return a * 32'd3 + 32'h1000_0001;
  endfunction

  function automatic logic [31:0] shifted(input logic [31:0] c);
    return {c[31:30], c[19:0], 10'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    brk_req_i = 0; mmu_req_i = 0; irq_req_i = 0;
  endtask

  // Inputs set at a negedge; this waits through the accepting edge and serves the read.
  task automatic serve(input logic [31:0] ea, ep_erp, ep_ccs, input int rdy_dly, rsp_dly,
                       input bit keep, input string tag);
    @(negedge clk);
    chk(busy_o === 1'b1, {tag, " R11 busy after accept"}, {31'd0, busy_o}, 32'd1);
    if (!keep) clear_reqs();
    chk(rd_valid_o === 1'b1 && rd_addr_o === ea, {tag, " R2 read address"}, rd_addr_o, ea);
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk(rd_valid_o === 1'b1 && rd_addr_o === ea, {tag, " R2 held while stalled"}, rd_addr_o, ea);
    end
    rd_ready_i = 1;
    @(negedge clk);
    rd_ready_i = 0;
    chk(rd_valid_o === 1'b0, {tag, " R2 valid drops after ready"}, {31'd0, rd_valid_o}, 32'd0);
    for (int i = 0; i < rsp_dly; i++) begin
      @(negedge clk);
      chk(busy_o === 1'b1 && commit_o === 1'b0, {tag, " R11 busy until data"}, {31'd0, busy_o}, 32'd1);
    end
    rd_rvalid_i = 1;
    rd_data_i   = tbl(ea);
    @(negedge clk);
    rd_rvalid_i = 0;
    chk(commit_o === 1'b1 && busy_o === 1'b0, {tag, " R10 commit strobe"}, {31'd0, commit_o}, 32'd1);
    chk(pc_o === tbl(ea), {tag, " R10 new pc"}, pc_o, tbl(ea));
    chk(erp_o === ep_erp, {tag, " return address"}, erp_o, ep_erp);
    chk(ccs_o === ep_ccs, {tag, " R8 status rewrite"}, ccs_o, ep_ccs);
  endtask

  task automatic t_reset();
    chk(pc_o === 0 && erp_o === 0 && ccs_o === 0, "R1 regs zero", pc_o | erp_o | ccs_o, 32'd0);
    chk(!busy_o && !commit_o && !rd_valid_o, "R1 flags low",
        {29'd0, busy_o, commit_o, rd_valid_o}, 32'd0);
  endtask

  task automatic t_break();
    pc_i = 32'h0000_1000; ccs_i = 32'hC00F_F00F; ebp_i = 32'h0000_8000;
    brk_vec_i = 8'h05; brk_req_i = 1;
    serve(32'h8014, 32'h1002, shifted(32'hC00F_F00F), 0, 0, 0, "R3 break");
    @(negedge clk);
    chk(commit_o === 1'b0, "R10 strobe one cycle", {31'd0, commit_o}, 32'd0);
  endtask

  task automatic t_fault();
    logic [31:0] old_erp = erp_o;
    pc_i = 32'h0000_2220; ccs_i = 32'hFFFF_FFFF; ebp_i = 32'h0001_0000;
    mmu_vec_i = 8'h11; mmu_req_i = 1;
    serve(32'h0001_0044, old_erp, 32'hFFFF_FC00, 2, 1, 0, "R4 fault");
  endtask

  task automatic t_low_vec();
    logic [31:0] p = pc_o, e = erp_o, c = ccs_o;
    pc_i = 32'h3000; ccs_i = 32'h0000_0008; irq_vec_i = 8'h2F; irq_req_i = 1;
    repeat (5) @(negedge clk);
    chk(!busy_o && !rd_valid_o, "R5 vector 0x2F ignored", {30'd0, busy_o, rd_valid_o}, 32'd0);
    chk(pc_o === p && erp_o === e && ccs_o === c && !commit_o, "R5 regs unchanged", pc_o, p);
    clear_reqs();
  endtask

  task automatic t_irq_mask();
    logic [31:0] p = pc_o;
    pc_i = 32'h0000_4440; ccs_i = 32'h4000_0000; ebp_i = 32'h0002_0000;
    irq_vec_i = 8'h30; irq_req_i = 1;
    repeat (5) @(negedge clk);
    chk(!busy_o && !rd_valid_o, "R6 masked interrupt not taken", {31'd0, busy_o}, 32'd0);
    chk(pc_o === p, "R6 pc unchanged while masked", pc_o, p);
    ccs_i = 32'h4000_0008;
    serve(32'h0002_00C0, 32'h4440, 32'h4000_2000, 1, 3, 0, "R7 R6 interrupt at 0x30");
  endtask

  task automatic t_priority();
    logic [31:0] old_erp;
    pc_i = 32'h5000; ccs_i = 32'h8000_0408; ebp_i = 32'h0;
    brk_vec_i = 8'h01; mmu_vec_i = 8'h02; irq_vec_i = 8'h40;
    brk_req_i = 1; mmu_req_i = 1; irq_req_i = 1;
    serve(32'h4, 32'h5002, shifted(32'h8000_0408), 0, 1, 0, "R9 break first");
    @(negedge clk);
    old_erp = erp_o;
    pc_i = 32'h6000;
    mmu_req_i = 1; irq_req_i = 1;
    serve(32'h8, old_erp, shifted(32'h8000_0408), 1, 0, 0, "R9 fault over interrupt");
  endtask

  task automatic t_busy();
    pc_i = 32'h7000; ccs_i = 32'h0000_0008; ebp_i = 32'h100;
    irq_vec_i = 8'h50; irq_req_i = 1;
    serve(32'h240, 32'h7000, 32'h0000_2000, 2, 2, 1, "R11 held request");
    pc_i = 32'h7100;
    @(negedge clk);
    chk(busy_o === 1'b1 && rd_addr_o === 32'h240, "R11 re-accept after commit", rd_addr_o, 32'h240);
    clear_reqs();
    rd_ready_i = 1;
    @(negedge clk);
    rd_ready_i = 0;
    rd_rvalid_i = 1; rd_data_i = tbl(32'h240);
    @(negedge clk);
    rd_rvalid_i = 0;
    chk(commit_o === 1'b1 && erp_o === 32'h7100, "R7 second entry saves new pc", erp_o, 32'h7100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_break();
    t_fault();
    t_low_vec();
    t_irq_mask();
    t_priority();
    t_busy();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule